// File: doc/BRIEF.md
# Flagged Integer Adder with Range Trap

This unit is the add slice of a simple execution stage. It takes a 32-bit first operand and, as the second operand, either a 32-bit register value or a 16-bit immediate that it widens by copying its sign bit. A 2-bit operation code picks between the four add forms. Two of the forms also add the stored carry flag as a third input. Every accepted add leaves a registered sum at the output, and it rewrites two persistent status bits: the unsigned carry out of the top bit and the signed two's-complement overflow. Both bits describe the complete sum, carry-in included.

The operand side and the result side are valid/ready streams. An operation is taken when `in_valid` and `in_ready` are both high on a rising edge. A sum stays on `out_sum` with `out_valid` high until the consumer raises `out_ready`. While a result waits, `in_ready` is low, and neither new operands nor flag updates from the issue path get in. A plain control port loads the carry flag, the overflow flag and the overflow-trap enable in one write.

When the trap enable is set, any accepted add whose own overflow is set raises `range_exc` for the single cycle after it is accepted. This holds whether or not carry is also set. A carry without overflow never raises it. Decoding, trap vectoring and register-file writeback happen elsewhere.

Top module: `addu_top`

## Requirements
- R1: An add accepted on a rising edge puts its sum on `out_sum` and sets `out_valid` from that edge. The sum is first operand plus second operand plus carry-in, modulo 2^32.
- R2: Each accepted add sets `carry_flag` to the carry out of bit 31 of its full sum, carry-in included. For example, 0xFFFFFFFF + 0x00000000 + 1 leaves carry set, in either operand order.
- R3: Each accepted add sets `ovf_flag` to the signed overflow of its full sum. A carry-in can cause overflow (0x40000000 + 0x3FFFFFFF + 1) and can also prevent it (0xC0000000 + 0xBFFFFFFF + 1).
- R4: Operation code bit 0 selects the carry-in. Codes 00 and 10 add zero whatever the stored carry flag holds. Codes 01 and 11 add the carry flag as it stood before the add.
- R5: Operation code bit 1 selects the second operand. Codes 10 and 11 use `in_imm` sign-extended from bit 15, so 0x8000 becomes 0xFFFF8000 and 0x7FFF stays 0x00007FFF. Codes 00 and 01 use `in_opb`.
- R6: `range_exc` is high for exactly the cycle after an accepted add whose own overflow is set while `ove_flag` is set. It stays low for carry-only results and whenever the enable is clear. A flag write in the same cycle does not suppress it.
- R7: The flags change only on an accepted add or a flag write. When both happen on the same edge, the written values win. `ove_flag` changes only on a flag write.
- R8: A synchronous active-high reset clears `carry_flag`, `ovf_flag`, `ove_flag`, `out_valid` and `range_exc`.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_sum` holds. When `out_ready` is high, the result leaves on that edge, and a new add can be accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code present |
| in_ready | output | 1 | Unit can take an add this cycle |
| in_op | input | 2 | bit1: immediate second operand; bit0: add stored carry |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Register second operand |
| in_imm | input | 16 | Immediate second operand, sign-extended |
| out_valid | output | 1 | Registered sum present |
| out_ready | input | 1 | Consumer takes the sum |
| out_sum | output | 32 | Registered sum |
| flag_wr | input | 1 | Load the three status bits below |
| flag_wr_carry | input | 1 | Value written to the carry flag |
| flag_wr_ovf | input | 1 | Value written to the overflow flag |
| flag_wr_ove | input | 1 | Value written to the trap enable |
| carry_flag | output | 1 | Stored carry flag |
| ovf_flag | output | 1 | Stored overflow flag |
| ove_flag | output | 1 | Stored overflow-trap enable |
| range_exc | output | 1 | One-cycle range trap request |

## Verification
The bench drives the carry-in edge cases: all-ones plus zero plus one in both operand orders, a carry-in that tips a positive sum into overflow, and one that pulls a negative sum back out of it. A design that takes overflow from the two operands alone, or carry from a 32-bit sum, reports the wrong flag there. It sets the stored carry before the plain forms, so a design that adds it unconditionally returns a sum one too high. Immediates 0x8000 and 0x7FFF catch zero-extension. The trap is checked on carry-only, overflow-only and both-set results, so a trap tied to carry or to the flag register shows up. Back-pressure, and a flag write colliding with an issue, expose a design that overwrites a waiting sum or lets the issue path win.

// File: rtl/addu_pkg.sv
package addu_pkg;
  // bit1: immediate operand, bit0: carry-in from flag
  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_ADDC  = 2'b01,
    OP_ADDI  = 2'b10,
    OP_ADDIC = 2'b11
  } addu_op_e;

  function automatic logic op_uses_imm(addu_op_e op);
    return op[1];
  endfunction

  function automatic logic op_uses_cin(addu_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/addu_operand_sel.sv
module addu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  addu_pkg::addu_op_e op,
  input  logic [DATA_W-1:0]  opb,
  input  logic [IMM_W-1:0]   imm,
  input  logic               carry_q,
  output logic [DATA_W-1:0]  b_eff,
  output logic               cin
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    b_eff = addu_pkg::op_uses_imm(op) ? imm_ext : opb;
    cin   = addu_pkg::op_uses_cin(op) & carry_q;
  end
endmodule

// File: rtl/addu_core.sv
module addu_core #(
  parameter int DATA_W    = 32,
  parameter bit OVF_CARRY = 1'b0  // 1: overflow from carries around msb
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    sum  = full[DATA_W-1:0];
    cout = full[DATA_W];
  end

  generate
    if (OVF_CARRY) begin : g_ovf_cc
      logic [LOW_W:0] low;
      always_comb begin
        low = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        ovf = low[LOW_W] ^ full[DATA_W];
      end
    end else begin : g_ovf_sign
      always_comb begin
        ovf = (a[DATA_W-1] == b[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
      end
    end
  endgenerate
endmodule

// File: rtl/addu_flag_regs.sv
module addu_flag_regs (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic res_carry,
  input  logic res_ovf,
  input  logic wr,
  input  logic wr_carry,
  input  logic wr_ovf,
  input  logic wr_ove,
  output logic carry_q,
  output logic ovf_q,
  output logic ove_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
      ove_q   <= 1'b0;
    end else if (wr) begin
      carry_q <= wr_carry;
      ovf_q   <= wr_ovf;
      ove_q   <= wr_ove;
    end else if (issue) begin
      carry_q <= res_carry;
      ovf_q   <= res_ovf;
    end
  end
endmodule

// File: rtl/addu_top.sv
module addu_top #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter bit OVF_CARRY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sum,
  input  logic              flag_wr,
  input  logic              flag_wr_carry,
  input  logic              flag_wr_ovf,
  input  logic              flag_wr_ove,
  output logic              carry_flag,
  output logic              ovf_flag,
  output logic              ove_flag,
  output logic              range_exc
);
  addu_pkg::addu_op_e op_e;
  logic [DATA_W-1:0]  b_eff;
  logic               cin;
  logic [DATA_W-1:0]  sum_c;
  logic               cout_c;
  logic               ovf_c;
  logic               take;

  assign op_e     = addu_pkg::addu_op_e'(in_op);
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  addu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op      (op_e),
    .opb     (in_opb),
    .imm     (in_imm),
    .carry_q (carry_flag),
    .b_eff   (b_eff),
    .cin     (cin)
  );

  addu_core #(.DATA_W(DATA_W), .OVF_CARRY(OVF_CARRY)) u_core (
    .a    (in_opa),
    .b    (b_eff),
    .cin  (cin),
    .sum  (sum_c),
    .cout (cout_c),
    .ovf  (ovf_c)
  );

  addu_flag_regs u_flags (
    .clk       (clk),
    .rst       (rst),
    .issue     (take),
    .res_carry (cout_c),
    .res_ovf   (ovf_c),
    .wr        (flag_wr),
    .wr_carry  (flag_wr_carry),
    .wr_ovf    (flag_wr_ovf),
    .wr_ove    (flag_wr_ove),
    .carry_q   (carry_flag),
    .ovf_q     (ovf_flag),
    .ove_q     (ove_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      range_exc <= 1'b0;
      out_sum   <= '0;
    end else begin
      range_exc <= take & ovf_c & ove_flag;
      if (take) begin
        out_valid <= 1'b1;
        out_sum   <= sum_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addu_checker.sv
module addu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_sum,
  input logic              flag_wr,
  input logic              flag_wr_carry,
  input logic              flag_wr_ovf,
  input logic              flag_wr_ove,
  input logic              carry_flag,
  input logic              ovf_flag,
  input logic              ove_flag,
  input logic              range_exc
);
  assert_take_gives_valid_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_trap_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    range_exc |-> $past(ove_flag) && $past(in_valid && in_ready));

  assert_flags_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !flag_wr) |=>
      $stable(carry_flag) && $stable(ovf_flag) && $stable(ove_flag));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> carry_flag == $past(flag_wr_carry) &&
                ovf_flag == $past(flag_wr_ovf) &&
                ove_flag == $past(flag_wr_ove));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !carry_flag && !ovf_flag && !ove_flag && !out_valid && !range_exc);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sum));

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind addu_top addu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/addu_top_tb.sv
`timescale 1ns/1ps
module addu_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_opa = '0, in_opb = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_sum;
  logic        flag_wr = 1'b0, flag_wr_carry = 1'b0, flag_wr_ovf = 1'b0, flag_wr_ove = 1'b0;
  logic        carry_flag, ovf_flag, ove_flag, range_exc;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addu_top u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the requirements
  function automatic logic [33:0] ref_add(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] imm, logic cf);
    logic [31:0] bb;
    logic [32:0] s;
    logic        o;
    bb = op[1] ? {{16{imm[15]}}, imm} : b;
    s  = {1'b0, a} + {1'b0, bb} + {32'd0, op[0] & cf};
    o  = (a[31] == bb[31]) && (s[31] != a[31]);
    return {o, s};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // directed: preset flags, issue, check result and trap pulse
  task automatic dir(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                     logic cf_pre, logic ove, logic [31:0] es, logic ec, logic eo,
                     logic ex, string tag);
    @(negedge clk);
    flag_wr = 1; flag_wr_carry = cf_pre; flag_wr_ovf = 0; flag_wr_ove = ove;
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    flag_wr = 0;
    in_valid = 1; in_op = op; in_opa = a; in_opb = b; in_imm = imm;
    @(posedge clk); #1;
    chk({tag, " R1 valid"}, {31'd0, out_valid}, 1);
    chk({tag, " sum"}, out_sum, es);
    chk({tag, " R2 carry"}, {31'd0, carry_flag}, {31'd0, ec});
    chk({tag, " R3 ovf"}, {31'd0, ovf_flag}, {31'd0, eo});
    chk({tag, " R6 trap"}, {31'd0, range_exc}, {31'd0, ex});
    @(negedge clk);
    in_valid = 0;
    @(posedge clk); #1;
    chk({tag, " R6 pulse end"}, {31'd0, range_exc}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 carry", {31'd0, carry_flag}, 0);
    chk("R8 ovf", {31'd0, ovf_flag}, 0);
    chk("R8 ove", {31'd0, ove_flag}, 0);
    chk("R8 valid", {31'd0, out_valid}, 0);
    chk("R8 trap", {31'd0, range_exc}, 0);
    @(negedge clk); rst = 0;

    dir(2'b00, 32'h1, 32'h2, 16'h0, 1, 0, 32'h3, 0, 0, 0, "R4 add ignores cf");
    dir(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 16'h0, 0, 0, 32'hFFFFFFFD, 1, 0, 0, "R2 neg+neg");
    dir(2'b00, 32'h40000000, 32'h40000000, 16'h0, 0, 0, 32'h80000000, 0, 1, 0, "R3 pos ovf");
    dir(2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 0, 0, 32'h7FFFFFFE, 1, 1, 0, "R3 both");
    dir(2'b00, 32'h40000000, 32'h40000000, 16'h0, 0, 1, 32'h80000000, 0, 1, 1, "R6 ovf trap");
    dir(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 16'h0, 0, 1, 32'hFFFFFFFD, 1, 0, 0, "R6 carry no trap");
    dir(2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 0, 1, 32'h7FFFFFFE, 1, 1, 1, "R6 both trap");
    dir(2'b01, 32'hFFFFFFFF, 32'h0, 16'h0, 1, 0, 32'h0, 1, 0, 0, "R2 addc wrap ab");
    dir(2'b01, 32'h0, 32'hFFFFFFFF, 16'h0, 1, 0, 32'h0, 1, 0, 0, "R2 addc wrap ba");
    dir(2'b01, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1, 1, 32'h80000000, 0, 1, 1, "R3 cin makes ovf");
    dir(2'b01, 32'hC0000000, 32'hBFFFFFFF, 16'h0, 1, 0, 32'h80000000, 1, 0, 0, "R3 cin avoids ovf");
    dir(2'b01, 32'h1, 32'h2, 16'h0, 0, 0, 32'h3, 0, 0, 0, "R4 addc cf clear");
    dir(2'b10, 32'h1, 32'hDEAD, 16'h0002, 1, 0, 32'h3, 0, 0, 0, "R4 addi ignores cf");
    dir(2'b10, 32'h80008000, 32'h0, 16'h8000, 0, 0, 32'h80000000, 1, 0, 0, "R5 sext neg");
    dir(2'b10, 32'h7FFF8000, 32'h0, 16'h7FFF, 0, 0, 32'h7FFFFFFF, 0, 0, 0, "R5 sext pos");
    dir(2'b10, 32'h7FFFC000, 32'h0, 16'h4000, 0, 1, 32'h80000000, 0, 1, 1, "R5 addi ovf trap");
    dir(2'b11, 32'h0, 32'h0, 16'hFFFF, 1, 0, 32'h0, 1, 0, 0, "R5 addic wrap");
    dir(2'b11, 32'h80007FFF, 32'h0, 16'h8000, 1, 0, 32'h80000000, 1, 0, 0, "R4 addic cin");
    dir(2'b11, 32'h7FFFC000, 32'h0, 16'h3FFF, 1, 1, 32'h80000000, 0, 1, 1, "R6 addic cin trap");

    // R7: write collides with overflowing issue; write wins, sum still lands
    @(negedge clk);
    flag_wr = 1; flag_wr_carry = 0; flag_wr_ovf = 0; flag_wr_ove = 0;
    in_valid = 1; in_op = 2'b00; in_opa = 32'hBFFFFFFF; in_opb = 32'hBFFFFFFF;
    @(posedge clk); #1;
    chk("R7 write wins carry", {31'd0, carry_flag}, 0);
    chk("R7 write wins ovf", {31'd0, ovf_flag}, 0);
    chk("R7 sum lands", out_sum, 32'h7FFFFFFE);
    @(negedge clk); flag_wr = 0; in_valid = 0;
    @(posedge clk); #1;
    chk("R7 idle keeps carry", {31'd0, carry_flag}, 0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_op = 2'b00; in_opa = 32'h10; in_opb = 32'h20;
    @(posedge clk); #1;
    chk("R9 first sum", out_sum, 32'h30);
    @(negedge clk);
    in_opa = 32'hFFFFFFFF; in_opb = 32'hFFFFFFFF; #1;
    chk("R9 stall ready", {31'd0, in_ready}, 0);
    @(posedge clk); #1;
    chk("R9 sum held", out_sum, 32'h30);
    chk("R9 flags untouched", {31'd0, carry_flag}, 0);
    @(negedge clk); out_ready = 1; #1;
    chk("R9 ready when drained", {31'd0, in_ready}, 1);
    @(posedge clk); #1;
    chk("R9 next sum", out_sum, 32'hFFFFFFFE);
    chk("R2 next carry", {31'd0, carry_flag}, 1);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R9 drained", {31'd0, out_valid}, 0);

    // random phase against a reference model
    begin
      logic m_cf, m_of, m_ove, m_ov, m_exc;
      logic [31:0] m_sum;
      m_cf = carry_flag; m_of = ovf_flag; m_ove = ove_flag; m_ov = out_valid;
      m_sum = out_sum; m_exc = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        logic acc;
        logic [33:0] r;
        @(negedge clk);
        in_valid  = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
        in_op     = 2'($urandom);
        case ($urandom % 4)
          0: in_opa = 32'h7FFFFFFF - 32'($urandom % 4);
          1: in_opa = 32'h80000000 + 32'($urandom % 4);
          2: in_opa = 32'hFFFFFFFF - 32'($urandom % 2);
          default: in_opa = $urandom;
        endcase
        in_opb = ($urandom % 2) ? in_opa : $urandom;
        in_imm = 16'($urandom);
        flag_wr = ($urandom % 10) == 0;
        flag_wr_carry = 1'($urandom); flag_wr_ovf = 1'($urandom); flag_wr_ove = 1'($urandom);
        #1;
        chk("R9 rand ready", {31'd0, in_ready}, {31'd0, ~m_ov | out_ready});
        acc = in_valid && (!m_ov || out_ready);
        r = ref_add(in_op, in_opa, in_opb, in_imm, m_cf);
        m_exc = acc && r[33] && m_ove;
        if (acc) begin
          m_sum = r[31:0]; m_ov = 1'b1;
        end else if (out_ready) begin
          m_ov = 1'b0;
        end
        if (flag_wr) begin
          m_cf = flag_wr_carry; m_of = flag_wr_ovf; m_ove = flag_wr_ove;
        end else if (acc) begin
          m_cf = r[32]; m_of = r[33];
        end
        @(posedge clk); #1;
        chk("R1 rand valid", {31'd0, out_valid}, {31'd0, m_ov});
        if (m_ov) chk("R1 rand sum", out_sum, m_sum);
        chk("R2 rand carry", {31'd0, carry_flag}, {31'd0, m_cf});
        chk("R3 rand ovf", {31'd0, ovf_flag}, {31'd0, m_of});
        chk("R7 rand ove", {31'd0, ove_flag}, {31'd0, m_ove});
        chk("R6 rand trap", {31'd0, range_exc}, {31'd0, m_exc});
      end
    end
    finish_run();
  end
endmodule